// File: doc/BRIEF.md
# SDRAM Command Sequencer with Selectable Timing

The block drives a single-rank SDRAM over a 32-bit data path and handles one word per bus access. A bus master raises a request with a byte address, a direction and write data. The sequencer then opens the row, issues the column command and pulses a transfer acknowledge. It closes the row with an explicit precharge before it accepts the next access. A free-running timer issues periodic auto refresh whenever the sequencer is idle. After software has started initialisation, these refreshes are what bring the memory to a usable state.

Host software programs a 7-bit control register. Five bits each choose between a short and a long setting for one SDRAM timing, with one clock cycle as the time unit. Writing 1 to one bit launches a precharge of all banks. That bit reads back as 1 until the precharge has finished. Writing 1 to another bit arms a one-shot flag. The next bus access then becomes a Load Mode Register command, and its mode word is taken from the word address of that access.

Top module: `sdram_seq`

## Requirements
- R1: After reset the SDRAM pins carry NOP (cs_n,ras_n,cas_n,we_n = 0111), acc_ack is low and cfg_rdata reads 0.
- R2: For a read or write, acc_ack is high for exactly one cycle, and that cycle comes tRCD+1+C cycles after the ACTIVE cycle. tRCD is 1 cycle when cfg bit 1 is 0 and 2 cycles when it is 1. C is cfg bit 0. With the short tRCD, the acknowledge therefore falls on the 2nd clock after ACTIVE (bit 0 = 0) or the 3rd clock (bit 0 = 1).
- R3: Command codes on cs_n,ras_n,cas_n,we_n are: ACTIVE 0011, READ 0101, WRITE 0100, PRECHARGE 0010, AUTO REFRESH 0001 and LOAD MODE 0000. ACTIVE carries the row, which is byte-address bits [COL_W+ROW_W+1:COL_W+2]. READ and WRITE carry the column, which is bits [COL_W+1:2], with sd_a[10] low.
- R4: sd_dq_oe is high with sd_dq_o equal to the write data during the WRITE cycle. A read returns sd_dq_i on acc_rdata in the acknowledge cycle, and sd_dq_oe is low in that cycle.
- R5: Writing cfg bit 6 as 1 issues a PRECHARGE with sd_a[10] high. Bit 6 reads 1 during that command. It reads 0 from tRP+1 cycles after the command onward, where tRP is 1 cycle when cfg bit 3 is 0 and 2 cycles when it is 1.
- R6: READ or WRITE is issued exactly tRCD cycles after ACTIVE.
- R7: After a write, PRECHARGE comes 1+tWR cycles after the acknowledge, where tWR is 1 cycle when cfg bit 2 is 0 and 2 cycles when it is 1. After a read, PRECHARGE comes in the cycle directly after the acknowledge.
- R8: An ACTIVE never comes earlier than tRP+1 cycles after a PRECHARGE.
- R9: While the bus is idle, AUTO REFRESH repeats every REF_INTERVAL cycles.
- R10: When a refresh request and a bus access are both pending at the idle decision point, AUTO REFRESH is issued first.
- R11: After AUTO REFRESH the next command comes tRC+1 cycles later, where tRC is 3 cycles when cfg bit 4 is 0 and 4 cycles when it is 1.
- R12: While cfg bit 5 is 1, the next access issues LOAD MODE with sd_a equal to byte-address bits [ROW_W+1:2] and no ACTIVE. acc_ack follows in the next cycle and bit 5 clears. The access after that is a normal one.
- R13: A cfg write stores bits 4..0 as written. Bits 5 and 6 are set only by writing 1, and writing 0 to them has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 7 | Control register write value |
| cfg_rdata | output | 7 | Control register read value |
| acc_req | input | 1 | Access request, held with its address and data until acknowledged |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Byte address |
| acc_wdata | input | DATA_W | Write word |
| acc_rdata | output | DATA_W | Read word, valid with acc_ack |
| acc_ack | output | 1 | Transfer acknowledge pulse |
| sd_cs_n | output | 1 | SDRAM chip select |
| sd_ras_n | output | 1 | SDRAM row strobe |
| sd_cas_n | output | 1 | SDRAM column strobe |
| sd_we_n | output | 1 | SDRAM write enable |
| sd_a | output | ROW_W | SDRAM address |
| sd_dq_o | output | DATA_W | Data driven to SDRAM |
| sd_dq_oe | output | 1 | Data output enable |
| sd_dq_i | input | DATA_W | Data returned by SDRAM |

## Verification
A refresh request and a bus access can both be waiting when the sequencer comes back to idle. The bench first learns the refresh phase from the spacing of earlier AUTO REFRESH commands. It then raises a read request in exactly the cycle in which the next refresh becomes pending. The collision counts as handled correctly only if AUTO REFRESH appears first, in the expected cycle, and ACTIVE follows exactly tRC+1 cycles later. This is repeated with both tRC settings.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PALL, ST_PALL_W, ST_AREF, ST_AREF_W, ST_ACT, ST_ACT_W, ST_RW,
    ST_CAS_W, ST_ACK, ST_WR_W, ST_PRE, ST_PRE_W, ST_LMR, ST_LMR_ACK
  } seq_state_t;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } sd_cmd_t;

  localparam sd_cmd_t CMD_NOP  = 4'b0111;
  localparam sd_cmd_t CMD_ACT  = 4'b0011;
  localparam sd_cmd_t CMD_RD   = 4'b0101;
  localparam sd_cmd_t CMD_WR   = 4'b0100;
  localparam sd_cmd_t CMD_PRE  = 4'b0010;
  localparam sd_cmd_t CMD_AREF = 4'b0001;
  localparam sd_cmd_t CMD_LMR  = 4'b0000;

  // bit 6 down to bit 0 of the control register
  typedef struct packed {
    logic init_req;
    logic mode_req;
    logic rc_long;
    logic rp_long;
    logic wr_long;
    logic rcd_long;
    logic cas_long;
  } seq_cfg_t;

  // 25 ns or 50 ns budgets in cycles
  function automatic logic [2:0] short_long(input logic lng);
    return lng ? 3'd2 : 3'd1;
  endfunction

  // 75 ns or 100 ns budget in cycles
  function automatic logic [2:0] rc_cycles(input logic lng);
    return lng ? 3'd4 : 3'd3;
  endfunction

  // cycles from ACTIVE to the acknowledge
  function automatic logic [2:0] ack_latency(input logic rcd_l, input logic cas_l);
    return short_long(rcd_l) + 3'd1 + {2'b00, cas_l};
  endfunction

  function automatic logic [2:0] sat_inc(input logic [2:0] v);
    return (v == 3'd7) ? v : v + 3'd1;
  endfunction

endpackage

// File: rtl/sdram_dly_cnt.sv
module sdram_dly_cnt #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  AST_DLY_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && zero) |=> zero); // R11
endmodule

// File: rtl/sdram_ref_timer.sv
module sdram_ref_timer #(
  parameter int INTERVAL = 312
) (
  input  logic clk,
  input  logic rst_n,
  input  logic served,
  output logic pending
);
  localparam int CW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

  logic [CW-1:0] cnt;
  logic          tick;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      pending <= 1'b0;
    end else begin
      cnt <= tick ? '0 : cnt + 1'b1;
      if (tick)        pending <= 1'b1;
      else if (served) pending <= 1'b0;
    end
  end

  AST_REF_TICK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> pending); // R9
endmodule

// File: rtl/sdram_cfg_reg.sv
module sdram_cfg_reg
  import sdram_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_en,
  input  logic [6:0] wdata,
  input  logic     init_done,
  input  logic     mode_done,
  output seq_cfg_t cfg_q
);
  seq_cfg_t w;
  assign w = seq_cfg_t'(wdata);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else begin
      if (init_done) cfg_q.init_req <= 1'b0;
      if (mode_done) cfg_q.mode_req <= 1'b0;
      if (wr_en) begin
        cfg_q.rc_long  <= w.rc_long;
        cfg_q.rp_long  <= w.rp_long;
        cfg_q.wr_long  <= w.wr_long;
        cfg_q.rcd_long <= w.rcd_long;
        cfg_q.cas_long <= w.cas_long;
        if (w.init_req) cfg_q.init_req <= 1'b1;
        if (w.mode_req) cfg_q.mode_req <= 1'b1;
      end
    end
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && w.mode_req) |=> cfg_q.mode_req); // R13
endmodule

// File: rtl/sdram_seq.sv
module sdram_seq
  import sdram_seq_pkg::*;
#(
  parameter int ROW_W        = 12,
  parameter int COL_W        = 8,
  parameter int DATA_W       = 32,
  parameter int REF_INTERVAL = 312,
  parameter int ADDR_W       = ROW_W + COL_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [6:0]        cfg_wdata,
  output logic [6:0]        cfg_rdata,
  input  logic              acc_req,
  input  logic              acc_we,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic [DATA_W-1:0] acc_rdata,
  output logic              acc_ack,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [ROW_W-1:0]  sd_a,
  output logic [DATA_W-1:0] sd_dq_o,
  output logic              sd_dq_oe,
  input  logic [DATA_W-1:0] sd_dq_i
);
  localparam int DLY_W   = 2;
  localparam int PRE_BIT = 10;

  seq_state_t st, st_nx;
  seq_cfg_t   cfg_q;
  sd_cmd_t    cmd;
  logic       wr_q;
  logic       dly_load, dly_zero;
  logic [DLY_W-1:0] dly_val;
  logic       init_done, mode_done, ref_served, ref_pend;
  logic [2:0] t_rp, t_wr, t_rc;

  // named events for the assertions
  logic cmd_act, cmd_rw, cmd_pre, cmd_aref, cmd_lmr, ack_rw;
  logic [2:0] since_act, since_rw, since_pre, since_ref;
  logic unused_addr;

  assign unused_addr = ^acc_addr[1:0];
  assign t_rp = short_long(cfg_q.rp_long);
  assign t_wr = short_long(cfg_q.wr_long);
  assign t_rc = rc_cycles(cfg_q.rc_long);

  sdram_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .wdata(cfg_wdata),
    .init_done(init_done), .mode_done(mode_done), .cfg_q(cfg_q)
  );

  sdram_ref_timer #(.INTERVAL(REF_INTERVAL)) u_ref (
    .clk(clk), .rst_n(rst_n), .served(ref_served), .pending(ref_pend)
  );

  sdram_dly_cnt #(.W(DLY_W)) u_dly (
    .clk(clk), .rst_n(rst_n), .load(dly_load), .load_val(dly_val), .zero(dly_zero)
  );

  always_comb begin
    st_nx      = st;
    dly_load   = 1'b0;
    dly_val    = '0;
    init_done  = 1'b0;
    mode_done  = 1'b0;
    ref_served = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (cfg_q.init_req)  st_nx = ST_PALL;
        else if (ref_pend)   st_nx = ST_AREF;
        else if (acc_req)    st_nx = cfg_q.mode_req ? ST_LMR : ST_ACT;
      end
      ST_PALL: begin
        st_nx = ST_PALL_W; dly_load = 1'b1; dly_val = DLY_W'(t_rp - 3'd1);
      end
      ST_PALL_W: if (dly_zero) begin st_nx = ST_IDLE; init_done = 1'b1; end
      ST_AREF: begin
        st_nx = ST_AREF_W; dly_load = 1'b1; dly_val = DLY_W'(t_rc - 3'd2);
        ref_served = 1'b1;
      end
      ST_AREF_W: if (dly_zero) st_nx = ST_IDLE;
      ST_ACT: begin
        if (cfg_q.rcd_long) begin st_nx = ST_ACT_W; dly_load = 1'b1; end
        else st_nx = ST_RW;
      end
      ST_ACT_W: if (dly_zero) st_nx = ST_RW;
      ST_RW: begin
        if (cfg_q.cas_long) begin st_nx = ST_CAS_W; dly_load = 1'b1; end
        else st_nx = ST_ACK;
      end
      ST_CAS_W: if (dly_zero) st_nx = ST_ACK;
      ST_ACK: begin
        if (wr_q) begin
          st_nx = ST_WR_W; dly_load = 1'b1; dly_val = DLY_W'(t_wr - 3'd1);
        end else st_nx = ST_PRE;
      end
      ST_WR_W: if (dly_zero) st_nx = ST_PRE;
      ST_PRE: begin
        st_nx = ST_PRE_W; dly_load = 1'b1; dly_val = DLY_W'(t_rp - 3'd1);
      end
      ST_PRE_W: if (dly_zero) st_nx = ST_IDLE;
      ST_LMR: begin st_nx = ST_LMR_ACK; mode_done = 1'b1; end
      ST_LMR_ACK: st_nx = ST_IDLE;
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      wr_q <= 1'b0;
    end else begin
      st <= st_nx;
      if (st == ST_IDLE && st_nx == ST_ACT) wr_q <= acc_we;
    end
  end

  // Moore command and address decode
  always_comb begin
    cmd  = CMD_NOP;
    sd_a = '0;
    unique case (st)
      ST_PALL, ST_PRE: begin cmd = CMD_PRE; sd_a[PRE_BIT] = 1'b1; end
      ST_AREF: cmd = CMD_AREF;
      ST_ACT: begin cmd = CMD_ACT; sd_a = acc_addr[ADDR_W-1 -: ROW_W]; end
      ST_RW: begin
        cmd  = wr_q ? CMD_WR : CMD_RD;
        sd_a = {{(ROW_W-COL_W){1'b0}}, acc_addr[COL_W+1:2]};
      end
      ST_LMR: begin cmd = CMD_LMR; sd_a = acc_addr[ROW_W+1:2]; end
      default: ;
    endcase
  end

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
  assign sd_dq_o   = acc_wdata;
  assign sd_dq_oe  = (st == ST_RW) && wr_q;
  assign acc_ack   = (st == ST_ACK) || (st == ST_LMR_ACK);
  assign acc_rdata = sd_dq_i;
  assign cfg_rdata = cfg_q;

  assign cmd_act  = (cmd == CMD_ACT);
  assign cmd_rw   = (cmd == CMD_RD) || (cmd == CMD_WR);
  assign cmd_pre  = (cmd == CMD_PRE);
  assign cmd_aref = (cmd == CMD_AREF);
  assign cmd_lmr  = (cmd == CMD_LMR);
  assign ack_rw   = acc_ack && !cmd_lmr && (st == ST_ACK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_act <= 3'd7; since_rw <= 3'd7; since_pre <= 3'd7; since_ref <= 3'd7;
    end else begin
      since_act <= cmd_act  ? 3'd1 : sat_inc(since_act);
      since_rw  <= cmd_rw   ? 3'd1 : sat_inc(since_rw);
      since_pre <= cmd_pre  ? 3'd1 : sat_inc(since_pre);
      since_ref <= cmd_aref ? 3'd1 : sat_inc(since_ref);
    end
  end

  AST_ACK_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    ack_rw |-> since_act == ack_latency(cfg_q.rcd_long, cfg_q.cas_long)); // R2
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ack |=> !acc_ack); // R2
  AST_RCD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rw |-> since_act == short_long(cfg_q.rcd_long)); // R6
  AST_WR_RECOVERY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_pre && st == ST_PRE && wr_q) |-> since_rw >= t_wr + 3'd1); // R7
  AST_RP_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_act |-> since_pre >= t_rp + 3'd1); // R8
  AST_RC_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd != CMD_NOP && !cmd_aref) |-> since_ref >= t_rc + 3'd1); // R11
  AST_LMR_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_lmr |-> cfg_q.mode_req); // R12
  AST_DQ_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    sd_dq_oe |-> cmd == CMD_WR); // R4
endmodule

// File: tb/test_sdram_seq.sv
module test_sdram_seq;
  localparam int ROW_W = 12, COL_W = 8, DATA_W = 32, RI = 64;
  localparam int ADDR_W = ROW_W + COL_W + 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_wr = 1'b0;
  logic [6:0] cfg_wdata = '0, cfg_rdata;
  logic acc_req = 1'b0, acc_we = 1'b0, acc_ack;
  logic [ADDR_W-1:0] acc_addr = '0;
  logic [DATA_W-1:0] acc_wdata = '0, acc_rdata, sd_dq_o, sd_dq_i = '0;
  logic sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
  logic [ROW_W-1:0] sd_a;

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  // monitor records
  int act_cyc, rw_cyc, pre_cyc, ref_cyc, ref_prev, lmr_cyc;
  int act_cnt = 0, pre_cnt = 0, ref_cnt = 0, lmr_cnt = 0;
  logic [3:0] rw_cmd;
  logic [ROW_W-1:0] act_a, rw_a, pre_a, lmr_a;
  logic rw_oe;
  logic [DATA_W-1:0] rw_dq;

  sdram_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .REF_INTERVAL(RI)) i_sdram_seq (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .acc_req(acc_req), .acc_we(acc_we), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .acc_rdata(acc_rdata), .acc_ack(acc_ack), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
    .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_a(sd_a), .sd_dq_o(sd_dq_o),
    .sd_dq_oe(sd_dq_oe), .sd_dq_i(sd_dq_i)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      case ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n})
        4'b0011: begin act_cyc = cyc; act_a = sd_a; act_cnt++; end
        4'b0101, 4'b0100: begin
          rw_cyc = cyc; rw_a = sd_a; rw_oe = sd_dq_oe; rw_dq = sd_dq_o;
          rw_cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
        end
        4'b0010: begin pre_cyc = cyc; pre_a = sd_a; pre_cnt++; end
        4'b0001: begin ref_prev = ref_cyc; ref_cyc = cyc; ref_cnt++; end
        4'b0000: begin lmr_cyc = cyc; lmr_a = sd_a; lmr_cnt++; end
        default: ;
      endcase
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic set_cfg(input logic [6:0] v);
    @(negedge clk); cfg_wr = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_wr = 1'b0; cfg_wdata = '0;
    #1;
  endtask

  task automatic do_access(input bit we, input logic [ADDR_W-1:0] addr, input logic [DATA_W-1:0] wd,
                           input bit want_pre, output int ack_c, output logic [DATA_W-1:0] rd,
                           output logic oe_at_ack);
    int n = 0;
    int p0 = pre_cnt;
    @(negedge clk); acc_req = 1'b1; acc_we = we; acc_addr = addr; acc_wdata = wd;
    #1;
    while (!acc_ack && n < 100) begin @(negedge clk); #1; n++; end
    ack_c = cyc; rd = acc_rdata; oe_at_ack = sd_dq_oe;
    acc_req = 1'b0;
    n = 0;
    while (want_pre && pre_cnt == p0 && n < 20) begin @(negedge clk); #1; n++; end
  endtask

  task automatic t_reset();
    chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111, "R1 cmd", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 4'b0111);
    chk(acc_ack == 1'b0, "R1 ack", acc_ack, 0);
    chk(cfg_rdata == 7'h00, "R1 cfg", cfg_rdata, 0);
  endtask

  task automatic t_cfg_bits();
    set_cfg(7'h15);
    chk(cfg_rdata == 7'h15, "R13 timing bits", cfg_rdata, 7'h15);
    set_cfg(7'h1A);
    chk(cfg_rdata == 7'h1A, "R13 rewrite", cfg_rdata, 7'h1A);
    set_cfg(7'h10);
  endtask

  task automatic t_init(input bit rp);
    int p0, n, clr;
    bit seen_high;
    p0 = pre_cnt; n = 0; clr = 0; seen_high = 0;
    set_cfg(7'h50 | (7'(rp) << 3));
    while (n < 40 && clr == 0) begin
      if (pre_cnt != p0 && cfg_rdata[6] && pre_cyc == cyc) seen_high = 1;
      if (pre_cnt != p0 && !cfg_rdata[6]) clr = cyc;
      @(negedge clk); #1; n++;
    end
    chk(pre_cnt != p0, "R5 precharge issued", pre_cnt - p0, 1);
    chk(pre_a[10] == 1'b1, "R5 A10 high", pre_a[10], 1);
    chk(seen_high, "R5 bit high during command", seen_high, 1);
    chk(clr - pre_cyc == (rp ? 3 : 2), "R5 clear cycle", clr - pre_cyc, rp ? 3 : 2);
  endtask

  task automatic t_rw(input bit cas, input bit rcd, input bit wr, input bit rp, input int seed);
    int ack_c, rcd_c, lat, pre_w;
    logic [DATA_W-1:0] rd, pat;
    logic oe;
    logic [ROW_W-1:0] row;
    logic [COL_W-1:0] col;
    logic [ADDR_W-1:0] addr;
    rcd_c = rcd ? 2 : 1;
    lat = rcd_c + 1 + int'(cas);
    row = ROW_W'(12'h5A3 ^ seed);
    col = COL_W'(8'h3C + seed);
    addr = {row, col, 2'b00};
    set_cfg(7'h10 | {2'b00, 1'b0, rp, wr, rcd, cas});
    tick(2);
    do_access(1'b1, addr, 32'hC0DE_0000 + seed, 1'b1, ack_c, rd, oe);
    chk(act_a == row, "R3 row on ACTIVE", act_a, row);
    chk(rw_cmd == 4'b0100, "R3 WRITE code", rw_cmd, 4'b0100);
    chk(rw_a == ROW_W'(col), "R3 column", rw_a, col);
    chk(rw_cyc - act_cyc == rcd_c, "R6 tRCD", rw_cyc - act_cyc, rcd_c);
    chk(rw_oe && rw_dq == 32'hC0DE_0000 + seed, "R4 write data", rw_dq, 32'hC0DE_0000 + seed);
    chk(ack_c - act_cyc == lat, "R2 write ack latency", ack_c - act_cyc, lat);
    chk(pre_cyc - ack_c == 1 + (wr ? 2 : 1), "R7 write recovery", pre_cyc - ack_c, 1 + (wr ? 2 : 1));
    pre_w = pre_cyc;
    pat = 32'h5EED_0000 ^ seed;
    sd_dq_i = pat;
    do_access(1'b0, addr ^ 22'h004, 32'h0, 1'b1, ack_c, rd, oe);
    chk(rw_cmd == 4'b0101, "R3 READ code", rw_cmd, 4'b0101);
    chk(rd == pat && !oe, "R4 read data", rd, pat);
    chk(ack_c - act_cyc == lat, "R2 read ack latency", ack_c - act_cyc, lat);
    chk(pre_cyc - ack_c == 1, "R7 read precharge", pre_cyc - ack_c, 1);
    chk(act_cyc - pre_w >= (rp ? 3 : 2), "R8 precharge gap", act_cyc - pre_w, rp ? 3 : 2);
    tick(4);
  endtask

  task automatic t_ref_period();
    int r0, n;
    r0 = ref_cnt; n = 0;
    while (ref_cnt < r0 + 3 && n < 400) begin @(negedge clk); #1; n++; end
    chk(ref_cnt >= r0 + 3, "R9 refresh running", ref_cnt - r0, 3);
    chk(ref_cyc - ref_prev == RI, "R9 refresh period", ref_cyc - ref_prev, RI);
  endtask

  task automatic t_collision(input bit rc);
    int r0, n, r, ack_c;
    logic [DATA_W-1:0] rd;
    logic oe;
    set_cfg({2'b00, rc, 4'b0000});
    r0 = ref_cnt; n = 0;
    while (ref_cnt == r0 && n < 200) begin @(negedge clk); #1; n++; end
    r = ref_cyc;
    while (cyc < r + RI - 1) begin @(negedge clk); #1; end
    acc_req = 1'b1; acc_we = 1'b0; acc_addr = 22'h01_2340;
    n = 0;
    while (!acc_ack && n < 100) begin @(negedge clk); #1; n++; end
    ack_c = cyc; rd = acc_rdata; oe = sd_dq_oe;
    acc_req = 1'b0;
    chk(ref_cyc == r + RI, "R10 refresh first", ref_cyc, r + RI);
    chk(act_cyc - ref_cyc == (rc ? 5 : 4), "R11 tRC", act_cyc - ref_cyc, rc ? 5 : 4);
    chk(ack_c > act_cyc && !oe, "R10 access served", ack_c - act_cyc, 2);
    tick(8);
  endtask

  task automatic t_mode_load();
    int a0, ack_c;
    logic [DATA_W-1:0] rd;
    logic oe;
    set_cfg(7'h30);
    chk(cfg_rdata[5] == 1'b1, "R12 armed", cfg_rdata[5], 1);
    a0 = act_cnt;
    do_access(1'b0, 22'h88, 32'h0, 1'b0, ack_c, rd, oe);
    chk(lmr_a == 12'h022, "R12 mode word", lmr_a, 12'h022);
    chk(ack_c - lmr_cyc == 1, "R12 ack after LOAD MODE", ack_c - lmr_cyc, 1);
    chk(act_cnt == a0, "R12 no ACTIVE", act_cnt - a0, 0);
    tick(1);
    chk(cfg_rdata[5] == 1'b0, "R12 bit cleared", cfg_rdata[5], 0);
    set_cfg(7'h10);
    chk(cfg_rdata[5] == 1'b0, "R13 zero write no effect", cfg_rdata[5], 0);
    do_access(1'b0, 22'h00_0400, 32'h0, 1'b1, ack_c, rd, oe);
    chk(act_cnt == a0 + 1, "R12 next access normal", act_cnt - a0, 1);
    tick(4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_cfg_bits();
    t_init(1'b0);
    t_init(1'b1);
    t_rw(1'b0, 1'b0, 1'b0, 1'b0, 1);
    t_rw(1'b1, 1'b0, 1'b1, 1'b0, 2);
    t_rw(1'b0, 1'b1, 1'b0, 1'b1, 3);
    t_rw(1'b1, 1'b1, 1'b1, 1'b1, 4);
    t_mode_load();
    t_ref_period();
    t_collision(1'b1);
    t_collision(1'b0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule